// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers a vector of interrupt request lines into a pending register and decides which one the core should service next. Each pending bit is filtered by a mask register, the lowest-numbered survivor wins, and the winner is offered to the core as a valid flag with an index. When the core acknowledges, the pending bit is cleared and the index becomes an active service level. A return-from-interrupt pulse retires the most recent level.

Three request lines, reset, emulation and power-down, bypass the mask. A global enable, off after reset, gates all servicing except the reset and emulation lines. Software can force or clear pending bits through a small register port. A nest-enable control bit selects between strictly sequential servicing and nested servicing, where a request may preempt a running routine only when its priority is strictly higher. Active levels are kept as a bit set, so the most recent level is always the highest-priority one present.

Top module: `irqc_top`

## Requirements
- R1: After reset, pending, mask and control read back as zero and `svc_valid_o` is low.
- R2: A high `req_i` bit sets its pending bit at the next clock edge, and the bit stays set after the line drops.
- R3: A write to address 0 sets every pending bit written as 1. A write to address 1 clears every pending bit written as 1. Reads of address 0 or 1 return the pending register.
- R4: A maskable request (index 3 and up) is offered only while its bit in the mask register (address 2) is 1.
- R5: Among the requests that may be offered, the lowest index wins.
- R6: Index 0 (reset), index 1 (emulation) and index 2 (power-down) are offered regardless of the mask register.
- R7: Control bit 5 is the global enable and is 0 after reset. While it is 0, only indices 0 and 1 are offered; power-down and all maskable requests wait.
- R8: Control (address 3) bit 4 is nest-enable. Every other control bit reads as 0 whatever is written to it.
- R9: `ack_i` while `svc_valid_o` is high clears the pending bit of `svc_idx_o` and marks that index active at the next edge. `ack_i` while `svc_valid_o` is low has no effect.
- R10: With nest-enable 0, nothing is offered while any level is active.
- R11: With nest-enable 1, a request is offered during an active routine only if its index is strictly lower than the lowest active index.
- R12: `rti_i` retires the lowest active index. With no level active it has no effect. When `rti_i` and an accepted `ack_i` coincide, the retire applies to the levels active before the acknowledge.
- R13: When a request line, or a set write, meets a clear of the same pending bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_IRQ | Request lines, index 0 highest priority |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 set-pending, 1 clear-pending, 2 mask, 3 control |
| wdata_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data for `addr_i`, combinational |
| ack_i | input | 1 | Core takes the offered request |
| rti_i | input | 1 | Core returns from the current routine |
| svc_valid_o | output | 1 | A request is offered to the core |
| svc_idx_o | output | $clog2(N_IRQ) | Index of the offered request |

## Verification
Every register result, whether pending, mask, control or active set, changes at the first clock edge after the inputs that cause it. `svc_valid_o`, `svc_idx_o` and `rd_data_o` are combinational from those registers, so each is due right after that same edge. The bench drives inputs at the falling edge, advances a reference model at the rising edge and compares all three outputs one nanosecond later. The expected offer comes from the model's state after the edge and never from the design.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_ADDR_W    = 2;
  localparam int CTRL_NEST_BIT = 4;
  localparam int CTRL_GIE_BIT  = 5;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_PSET = 2'd0,
    REG_PCLR = 2'd1,
    REG_MASK = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;

  // lowest set bit of a vector; 0 when the vector is empty
  function automatic logic [4:0] first_one(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // clears apply first, so any set source in the same cycle wins
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i | req_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
  parameter int N       = 16,
  parameter int RST_IDX = 0,
  parameter int EMU_IDX = 1,
  parameter int PWD_IDX = 2,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  input  logic [N-1:0]     mask_i,
  input  logic             gie_i,
  input  logic             nest_i,
  input  logic [N-1:0]     act_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [N-1:0] NO_MASK  = (N'(1) << RST_IDX) | (N'(1) << EMU_IDX) | (N'(1) << PWD_IDX);
  localparam logic [N-1:0] NO_GATE  = (N'(1) << RST_IDX) | (N'(1) << EMU_IDX);

  logic [N-1:0]     eligible;
  logic [IDX_W-1:0] win_idx;
  logic [IDX_W-1:0] top_idx;
  logic             any_act;
  logic             may_take;

  assign eligible = pend_i & (mask_i | NO_MASK) & (gie_i ? {N{1'b1}} : NO_GATE);
  assign win_idx  = IDX_W'(irqc_pkg::first_one(32'(eligible)));
  assign top_idx  = IDX_W'(irqc_pkg::first_one(32'(act_i)));
  assign any_act  = |act_i;
  assign may_take = !any_act || (nest_i && (win_idx < top_idx));
  assign valid_o  = (|eligible) && may_take;
  assign idx_o    = win_idx;
endmodule

// File: rtl/irqc_active.sv
module irqc_active #(
  parameter int N      = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_idx_i,
  input  logic             pop_i,
  output logic [N-1:0]     act_o
);
  logic [N-1:0] act_q;
  logic [N-1:0] after_pop;

  // levels nest in strictly rising priority, so the top is the lowest set bit
  assign after_pop = pop_i ? (act_q & (act_q - N'(1))) : act_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      act_q <= '0;
    else if (push_i) act_q <= after_pop | (N'(1) << push_idx_i);
    else             act_q <= after_pop;
  end

  assign act_o = act_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int N_IRQ   = 16,
  parameter int DATA_W  = 16,
  parameter int RST_IDX = 0,
  parameter int EMU_IDX = 1,
  parameter int PWD_IDX = 2,
  localparam int IDX_W  = $clog2(N_IRQ)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_IRQ-1:0]                req_i,
  input  logic                            wr_en_i,
  input  logic [irqc_pkg::REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rd_data_o,
  input  logic                            ack_i,
  input  logic                            rti_i,
  output logic                            svc_valid_o,
  output logic [IDX_W-1:0]                svc_idx_o
);
  import irqc_pkg::*;

  logic [N_IRQ-1:0] pend_q, mask_q, act_q, set_vec, clr_vec;
  logic             gie_q, nest_q, take;
  logic             wr_pset, wr_pclr, wr_mask, wr_ctrl;

  assign wr_pset = wr_en_i && (addr_i == REG_PSET);
  assign wr_pclr = wr_en_i && (addr_i == REG_PCLR);
  assign wr_mask = wr_en_i && (addr_i == REG_MASK);
  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);
  assign take    = ack_i && svc_valid_o;

  assign set_vec = wr_pset ? wdata_i[N_IRQ-1:0] : '0;
  assign clr_vec = (wr_pclr ? wdata_i[N_IRQ-1:0] : '0) |
                   (take ? (N_IRQ'(1) << svc_idx_o) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
      nest_q <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wdata_i[N_IRQ-1:0];
      if (wr_ctrl) begin
        gie_q  <= wdata_i[CTRL_GIE_BIT];
        nest_q <= wdata_i[CTRL_NEST_BIT];
      end
    end
  end

  irqc_pending #(.N(N_IRQ)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .set_i(set_vec), .clr_i(clr_vec), .pend_o(pend_q)
  );

  irqc_select #(.N(N_IRQ), .RST_IDX(RST_IDX), .EMU_IDX(EMU_IDX), .PWD_IDX(PWD_IDX)) u_sel (
    .pend_i(pend_q), .mask_i(mask_q), .gie_i(gie_q), .nest_i(nest_q),
    .act_i(act_q), .valid_o(svc_valid_o), .idx_o(svc_idx_o)
  );

  irqc_active #(.N(N_IRQ)) u_act (
    .clk(clk), .rst_n(rst_n), .push_i(take), .push_idx_i(svc_idx_o),
    .pop_i(rti_i), .act_o(act_q)
  );

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      REG_PSET, REG_PCLR: rd_data_o = DATA_W'(pend_q);
      REG_MASK:           rd_data_o = DATA_W'(mask_q);
      default: begin
        rd_data_o[CTRL_GIE_BIT]  = gie_q;
        rd_data_o[CTRL_NEST_BIT] = nest_q;
      end
    endcase
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N       = 16,
  parameter int RST_IDX = 0,
  parameter int EMU_IDX = 1,
  parameter int PWD_IDX = 2,
  localparam int IDX_W  = $clog2(N)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     req,
  input logic [N-1:0]     set_vec,
  input logic             take,
  input logic             rti,
  input logic             svc_valid,
  input logic [IDX_W-1:0] svc_idx,
  input logic [N-1:0]     pend,
  input logic [N-1:0]     mask,
  input logic [N-1:0]     act,
  input logic             gie,
  input logic             nest
);
  // R5
  offer_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> pend[svc_idx]);

  // R4
  offer_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (mask[svc_idx] || int'(svc_idx) == RST_IDX ||
                   int'(svc_idx) == EMU_IDX || int'(svc_idx) == PWD_IDX));

  // R7
  gie_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && !gie) |-> (int'(svc_idx) == RST_IDX || int'(svc_idx) == EMU_IDX));

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req[svc_idx] && !set_vec[svc_idx]) |=> !pend[$past(svc_idx)]);

  // R10
  no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && !nest) |-> (act == '0));

  // R11
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_valid && act != '0) |-> (svc_idx < IDX_W'(irqc_pkg::first_one(32'(act)))));

  // R12
  retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && !take && act != '0) |=> ($countones(act) == $countones($past(act)) - 1));
endmodule

bind irqc_top irqc_checker #(.N(N_IRQ), .RST_IDX(RST_IDX), .EMU_IDX(EMU_IDX), .PWD_IDX(PWD_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req_i), .set_vec(set_vec), .take(take), .rti(rti_i),
  .svc_valid(svc_valid_o), .svc_idx(svc_idx_o), .pend(pend_q), .mask(mask_q),
  .act(act_q), .gie(gie_q), .nest(nest_q)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
  localparam int N = 16;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rd_data;
  logic         ack = 1'b0, rti = 1'b0;
  logic         svc_valid;
  logic [3:0]   svc_idx;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference state
  logic [N-1:0] m_pend = '0, m_mask = '0, m_act = '0;
  logic         m_gie = 1'b0, m_nest = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top u_irqc_top (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rd_data_o(rd_data), .ack_i(ack), .rti_i(rti),
    .svc_valid_o(svc_valid), .svc_idx_o(svc_idx)
  );

  function automatic bit may_offer(int i);
    if (!m_pend[i]) return 0;
    if (i > 2 && !m_mask[i]) return 0;
    if (!m_gie && i > 1) return 0;
    return 1;
  endfunction

  function automatic void expect_offer(output bit v, output int idx);
    int top = N;
    v = 0; idx = 0;
    for (int i = N - 1; i >= 0; i--) if (m_act[i]) top = i;
    for (int i = 0; i < N; i++) begin
      if (may_offer(i)) begin
        idx = i;
        v = (top == N) || (m_nest && i < top);
        return;
      end
    end
  endfunction

  function automatic logic [W-1:0] expect_read(logic [1:0] a);
    case (a)
      2'd0, 2'd1: return m_pend;
      2'd2:       return m_mask;
      default:    return W'({m_gie, m_nest}) << 4;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act_v, logic [31:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  // one cycle: drive at falling edge, advance model at rising edge, compare after
  task automatic step(string tag, logic [N-1:0] r, bit we, logic [1:0] a,
                      logic [W-1:0] d, bit k, bit q);
    bit ev; int ei;
    logic [N-1:0] clr, set;
    @(negedge clk);
    req = r; wr_en = we; addr = a; wdata = d; ack = k; rti = q;
    expect_offer(ev, ei);
    @(posedge clk);
    set = (we && a == 2'd0) ? d : '0;
    clr = (we && a == 2'd1) ? d : '0;
    if (k && ev) clr[ei] = 1'b1;
    m_pend = (m_pend & ~clr) | set | r;
    if (we && a == 2'd2) m_mask = d;
    if (we && a == 2'd3) begin m_gie = d[5]; m_nest = d[4]; end
    if (q) m_act = m_act & (m_act - 1'b1);
    if (k && ev) m_act[ei] = 1'b1;
    #1;
    expect_offer(ev, ei);
    check({tag, " valid"}, 32'(svc_valid), 32'(ev));
    if (ev) check({tag, " idx"}, 32'(svc_idx), 32'(ei));
    check({tag, " read"}, 32'(rd_data), 32'(expect_read(a)));
  endtask

  task automatic idle(string tag, logic [1:0] a);
    step(tag, '0, 0, a, '0, 0, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 valid", 32'(svc_valid), 0);
    for (int a = 0; a < 4; a++) idle("R1", 2'(a));
    // R2 request latches and holds
    step("R2", 16'h0080, 0, 2'd0, '0, 0, 0);
    idle("R2", 2'd0);
    check("R2 hold", 32'(rd_data), 32'h0080);
    // R3 set and clear writes
    step("R3", '0, 1, 2'd0, 16'h0300, 0, 0);
    step("R3", '0, 1, 2'd1, 16'h0100, 0, 0);
    check("R3 pend", 32'(rd_data), 32'h0280);
    // R7 power-down waits, emulation goes through while disabled
    step("R7", '0, 1, 2'd1, 16'hFFFF, 0, 0);
    step("R7", '0, 1, 2'd0, 16'h0004, 0, 0);
    check("R7 pwd blocked", 32'(svc_valid), 0);
    step("R7", '0, 1, 2'd0, 16'h0002, 0, 0);
    check("R7 emu idx", 32'(svc_idx), 1);
    step("R7", '0, 1, 2'd1, 16'hFFFF, 0, 0);
    // R4 mask gating, R5 priority, R6 unmaskable
    step("R4", '0, 1, 2'd3, 16'h0020, 0, 0);
    step("R4", '0, 1, 2'd0, 16'h0180, 0, 0);
    check("R4 masked", 32'(svc_valid), 0);
    step("R4", '0, 1, 2'd2, 16'h0100, 0, 0);
    check("R4 idx", 32'(svc_idx), 8);
    step("R5", '0, 1, 2'd2, 16'h0180, 0, 0);
    check("R5 idx", 32'(svc_idx), 7);
    step("R6", '0, 1, 2'd0, 16'h0004, 0, 0);
    check("R6 idx", 32'(svc_idx), 2);
    // R9 acknowledge, R10 sequential hold-off
    step("R9", '0, 0, 2'd0, '0, 1, 0);
    check("R9 pend", 32'(rd_data), 32'h0180);
    check("R10 held", 32'(svc_valid), 0);
    step("R9 ignored ack", '0, 0, 2'd0, '0, 1, 0);
    check("R9 ignored", 32'(rd_data), 32'h0180);
    // R12 retire
    step("R12", '0, 0, 2'd0, '0, 0, 1);
    check("R12 idx", 32'(svc_idx), 7);
    // R11 nesting
    step("R11", '0, 1, 2'd3, 16'h0030, 0, 0);
    step("R11", '0, 0, 2'd0, '0, 1, 0);
    check("R11 lower waits", 32'(svc_valid), 0);
    step("R11", '0, 1, 2'd2, 16'h0188, 0, 0);
    step("R11", '0, 1, 2'd0, 16'h0008, 0, 0);
    check("R11 preempt", 32'(svc_idx), 3);
    step("R11", '0, 0, 2'd0, '0, 1, 0);
    step("R12", '0, 0, 2'd0, '0, 0, 1);
    check("R12 still held", 32'(svc_valid), 0);
    step("R12", '0, 0, 2'd0, '0, 0, 1);
    check("R12 idx8", 32'(svc_idx), 8);
    step("R12 empty", '0, 0, 2'd0, '0, 0, 1);
    // R13 set beats clear
    step("R13", 16'h0100, 1, 2'd1, 16'h0100, 0, 0);
    check("R13 kept", 32'(rd_data), 32'h0100);
    // R8 reserved control bits
    step("R8", '0, 1, 2'd3, 16'hFFFF, 0, 0);
    check("R8 ctrl", 32'(rd_data), 32'h0030);
    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] r;
      bit we;
      r = ($urandom % 8 == 0) ? N'(1) << ($urandom % N) : '0;
      we = ($urandom % 6 == 0);
      step("R5 random", r, we, 2'($urandom), W'($urandom), ($urandom % 3 == 0),
           ($urandom % 5 == 0));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule